// File: doc/BRIEF.md
# Two-Wire Slave Bus Front End with Busy Refusal

This block is the slave side of a two-wire serial bus for a small register device that holds 10-bit values. It recovers the clock and data lines inside a fast system clock domain and detects start and stop conditions. It takes in an identification byte and checks it against a fixed device type and three strap inputs. It then receives an instruction byte, followed by data bytes on a write or by bytes it sends back on a read. Each received byte goes to a command executor over a valid/ready pair. Read bytes come from the executor and are shifted out MSB first.

While the executor reports a nonvolatile write in progress, the block does not acknowledge its own identification byte. A host can therefore poll for completion by sending the address repeatedly. A 10-bit value travels as two bytes. The first byte carries six don't-care bits and then bits 9 and 8, and the second byte carries bits 7 to 0. The executor assembles and interprets these bytes. The data line is open drain: `sdaOut` is tied to zero, and `sdaOe` high pulls the line low.

Top module: `twslv_front`

## Requirements
- R1: After reset, and for any traffic not preceded by a start condition (SDA falling while SCL is high), `sdaOe` stays 0 and no byte is delivered.
- R2: An identification byte whose bits 7:4 equal 0101 and whose bits 3:1 equal `devAddr` is acknowledged: SDA is held low for the whole ninth clock. Bit 0 is 1 for a read and is reported on `cmdRead`.
- R3: An identification byte with a wrong type or a wrong address gets no acknowledge, and no bytes are delivered until the next start condition.
- R4: While `nvBusy` is 1, a matching identification byte is not acknowledged. Once `nvBusy` returns to 0, the same byte is acknowledged.
- R5: The byte after an acknowledged identification byte is acknowledged and delivered with `cmdInstr`=1.
- R6: On a write, every further byte is sampled MSB first on the rising edges of SCL, acknowledged, and delivered with `cmdInstr`=0. A 10-bit value arrives as an upper byte (bits 1:0 = value bits 9:8) followed by a lower byte.
- R7: On a read, `rdTake` pulses at the falling SCL edge that ends the instruction acknowledge, and `rdData` is sampled at that moment. The byte is driven MSB first, and each bit changes only after a falling SCL edge.
- R8: During the acknowledge slot of a byte the block sends, it releases SDA. A master ACK (SDA low) loads the next byte through another `rdTake`. A NACK stops transmission, and SDA stays released until the next start or stop.
- R9: `cmdValid` stays 1, and `cmdData` stays unchanged, until a cycle in which `cmdReady` is 1. It falls after that cycle.
- R10: A start condition in the middle of a byte discards the partial byte and begins a new identification byte.
- R11: A stop condition (SDA rising while SCL is high) releases SDA and returns the block to idle. When the transaction had been addressed, `txnDone` pulses for one cycle.
- R12: A pulse on SCL shorter than `FILT_LEN` system clocks causes no bit to be sampled.
- R13: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls the data line low |
| sdaOut | output | 1 | Driven level when enabled, always 0 |
| devAddr | input | 3 | Strap value matched against ID bits 3:1 |
| nvBusy | input | 1 | Nonvolatile write in progress; refuse address |
| cmdValid | output | 1 | A received byte is waiting for the executor |
| cmdReady | input | 1 | Executor accepts the waiting byte |
| cmdData | output | 8 | The received byte |
| cmdInstr | output | 1 | 1 when the byte is the instruction byte |
| cmdRead | output | 1 | Read flag from the current identification byte |
| rdData | input | 8 | Next byte to send, sampled when rdTake is 1 |
| rdTake | output | 1 | One-cycle pulse: rdData was loaded for sending |
| txnDone | output | 1 | One-cycle pulse at the stop of an addressed transaction |

## Verification
On every cycle, the assertions check four things. The drive enable moves only while the clock line is low. A waiting byte is held until it is accepted. The first bit of each loaded read byte appears on the line in the cycle after the load. A stop leaves the line released. Other behaviours depend on whole bus sequences, and only the bench scenarios can show them: address matching and busy refusal, instruction and data byte delivery, MSB-first read data with master ACK and NACK, restart in the middle of a byte, and rejection of a short clock glitch.

// File: rtl/twslv_pkg.sv
package twslv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int ADDR_W = 3;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ID_ACK, S_INSTR, S_INSTR_ACK,
    S_WDATA, S_WDATA_ACK, S_RDATA, S_RDATA_ACK, S_WAIT
  } twsState_e;

  typedef struct packed {
    logic clrBits;
    logic cntUp;
    logic rxShift;
    logic txLoad;
    logic txShift;
    logic ackOn;
    logic sdaRel;
    logic capture;
  } twsStrobe_t;
endpackage

// File: rtl/twslv_datapath.sv
module twslv_datapath
  import twslv_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twsStrobe_t        strobe,
  input  logic [BYTE_W-1:0] rdData,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startSeen,
  output logic              stopSeen,
  output logic              bitsDone,
  output logic              sdaLevel,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] holdByte,
  output logic              sdaPull
);
  logic [1:0] rawLine, lineF, lineP;
  assign rawLine = {sdaIn, sclIn};

  // index 0 = clock line, index 1 = data line
  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [1:0]          syncQ;
    logic [FILT_LEN-1:0] winQ;
    logic                filtQ, prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        winQ  <= '1;
        filtQ <= 1'b1;
        prevQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawLine[g]};
        winQ  <= {winQ[FILT_LEN-2:0], syncQ[1]};
        if (&winQ) filtQ <= 1'b1;
        else if (!(|winQ)) filtQ <= 1'b0;
        prevQ <= filtQ;
      end
    end
    assign lineF[g] = filtQ;
    assign lineP[g] = prevQ;
  end

  assign sclRise   = lineF[0] & ~lineP[0];
  assign sclFall   = ~lineF[0] & lineP[0];
  assign startSeen = lineF[0] & lineP[0] & lineP[1] & ~lineF[1];
  assign stopSeen  = lineF[0] & lineP[0] & ~lineP[1] & lineF[1];
  assign sdaLevel  = lineF[1];

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftQ   <= '0;
      holdByte <= '0;
      sdaPull  <= 1'b0;
    end else begin
      if (strobe.clrBits) bitCnt <= '0;
      else if (strobe.cntUp) bitCnt <= bitCnt + 1'b1;

      if (strobe.txLoad) shiftQ <= rdData;
      else if (strobe.txShift) shiftQ <= {shiftQ[BYTE_W-2:0], 1'b0};
      else if (strobe.rxShift) shiftQ <= {shiftQ[BYTE_W-2:0], sdaLevel};

      if (strobe.capture) holdByte <= shiftQ;

      if (strobe.sdaRel) sdaPull <= 1'b0;
      else if (strobe.txLoad) sdaPull <= ~rdData[BYTE_W-1];
      else if (strobe.txShift) sdaPull <= ~shiftQ[BYTE_W-2];
      else if (strobe.ackOn) sdaPull <= 1'b1;
    end
  end

  assign bitsDone = (bitCnt == CNT_W'(BYTE_W));
  assign rxByte   = shiftQ;
endmodule

// File: rtl/twslv_control.sv
module twslv_control
  import twslv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startSeen,
  input  logic              stopSeen,
  input  logic              bitsDone,
  input  logic              sdaLevel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              nvBusy,
  input  logic              cmdReady,
  output twsStrobe_t        strobe,
  output logic              cmdValid,
  output logic              cmdInstr,
  output logic              cmdRead,
  output logic              rdTake,
  output logic              txnDone
);
  twsState_e state, stateNext;
  logic      masterAck;
  logic      idMatch;

  assign idMatch = (rxByte[7:4] == DEV_TYPE) && (rxByte[3:1] == devAddr) && !nvBusy;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (startSeen) begin
      strobe.clrBits = 1'b1;
      strobe.sdaRel  = 1'b1;
      stateNext      = S_ID;
    end else if (stopSeen) begin
      strobe.sdaRel = 1'b1;
      stateNext     = S_IDLE;
    end else begin
      unique case (state)
        S_ID, S_INSTR, S_WDATA: begin
          if (sclRise) begin
            strobe.rxShift = 1'b1;
            strobe.cntUp   = 1'b1;
          end else if (sclFall && bitsDone) begin
            if (state == S_ID) begin
              strobe.ackOn = idMatch;
              stateNext    = idMatch ? S_ID_ACK : S_IDLE;
            end else begin
              strobe.ackOn   = 1'b1;
              strobe.capture = 1'b1;
              stateNext      = (state == S_INSTR) ? S_INSTR_ACK : S_WDATA_ACK;
            end
          end
        end
        S_ID_ACK, S_WDATA_ACK: begin
          if (sclFall) begin
            strobe.sdaRel  = 1'b1;
            strobe.clrBits = 1'b1;
            stateNext      = (state == S_ID_ACK) ? S_INSTR : S_WDATA;
          end
        end
        S_INSTR_ACK: begin
          if (sclFall) begin
            strobe.clrBits = 1'b1;
            if (cmdRead) begin
              strobe.txLoad = 1'b1;
              stateNext     = S_RDATA;
            end else begin
              strobe.sdaRel = 1'b1;
              stateNext     = S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (sclRise) strobe.cntUp = 1'b1;
          else if (sclFall) begin
            if (bitsDone) begin
              strobe.sdaRel = 1'b1;
              stateNext     = S_RDATA_ACK;
            end else strobe.txShift = 1'b1;
          end
        end
        S_RDATA_ACK: begin
          if (sclFall) begin
            if (masterAck) begin
              strobe.clrBits = 1'b1;
              strobe.txLoad  = 1'b1;
              stateNext      = S_RDATA;
            end else stateNext = S_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      masterAck <= 1'b0;
      cmdValid  <= 1'b0;
      cmdInstr  <= 1'b0;
      cmdRead   <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_RDATA_ACK && sclRise) masterAck <= ~sdaLevel;
      if (state == S_ID && strobe.ackOn) cmdRead <= rxByte[0];
      if (strobe.capture) begin
        cmdValid <= 1'b1;
        cmdInstr <= (state == S_INSTR);
      end else if (cmdValid && cmdReady) cmdValid <= 1'b0;
    end
  end

  assign rdTake  = strobe.txLoad;
  assign txnDone = stopSeen && (state != S_IDLE) && (state != S_ID);
endmodule

// File: rtl/twslv_front.sv
module twslv_front
  import twslv_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              sdaOut,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              nvBusy,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdInstr,
  output logic              cmdRead,
  input  logic [BYTE_W-1:0] rdData,
  output logic              rdTake,
  output logic              txnDone
);
  twsStrobe_t        strobe;
  logic              sclRise, sclFall, startSeen, stopSeen, bitsDone, sdaLevel;
  logic [BYTE_W-1:0] rxByte;

  twslv_datapath #(.FILT_LEN(FILT_LEN)) i_datapath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .rdData(rdData), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .bitsDone(bitsDone),
    .sdaLevel(sdaLevel), .rxByte(rxByte), .holdByte(cmdData), .sdaPull(sdaOe)
  );

  twslv_control i_control (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .bitsDone(bitsDone),
    .sdaLevel(sdaLevel), .rxByte(rxByte), .devAddr(devAddr), .nvBusy(nvBusy),
    .cmdReady(cmdReady), .strobe(strobe), .cmdValid(cmdValid),
    .cmdInstr(cmdInstr), .cmdRead(cmdRead), .rdTake(rdTake), .txnDone(txnDone)
  );

  assign sdaOut = 1'b0;
endmodule

// File: rtl/twslv_checker.sv
module twslv_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic [7:0] cmdData,
  input logic [7:0] rdData,
  input logic       rdTake,
  input logic       txnDone
);
  // R13: drive enable only turns on while the clock line is low
  a_r13_rise_in_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R13: drive enable only turns off while the clock line is low
  a_r13_fall_in_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> !sclIn);

  // R9: a waiting byte is held until accepted
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdData));

  // R7: the first bit of a loaded read byte reaches the line next cycle
  a_r7_first_bit: assert property (@(posedge clk) disable iff (!rstN)
    rdTake |=> sdaOe == !$past(rdData[7]));

  // R11: a stop leaves the line released
  a_r11_stop_release: assert property (@(posedge clk) disable iff (!rstN)
    txnDone |=> !sdaOe);
endmodule

bind twslv_front twslv_checker i_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdData(cmdData), .rdData(rdData), .rdTake(rdTake),
  .txnDone(txnDone)
);

// File: tb/test_twslv_front.sv
module test_twslv_front;
  localparam int H = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic       nvBusy = 1'b0;
  logic       cmdReady = 1'b0;
  logic [7:0] rdData = '0;
  logic       sdaOe, sdaOut, cmdValid, cmdInstr, cmdRead, rdTake, txnDone;
  logic [7:0] cmdData;
  wire        sdaLine = mSda & ~sdaOe;

  int nChecks = 0;
  int nFails = 0;
  int rdTakeCnt = 0;
  int txnCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twslv_front i_twslv_front (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .sdaOut(sdaOut), .devAddr(3'b101), .nvBusy(nvBusy), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .cmdInstr(cmdInstr),
    .cmdRead(cmdRead), .rdData(rdData), .rdTake(rdTake), .txnDone(txnDone)
  );

  always @(posedge clk) begin
    if (rdTake) rdTakeCnt <= rdTakeCnt + 1;
    if (txnDone) txnCnt <= txnCnt + 1;
  end

  // {id, instr, data16, busy, expected id ack}
  localparam logic [33:0] VEC [6] = '{
    {8'h5A, 8'hA0, 16'h0203, 1'b0, 1'b1},
    {8'h5A, 8'hC4, 16'hFCFF, 1'b0, 1'b1},
    {8'h58, 8'hA0, 16'h0111, 1'b0, 1'b0},
    {8'h7A, 8'hA0, 16'h0111, 1'b0, 1'b0},
    {8'h5A, 8'hA0, 16'h0111, 1'b1, 1'b0},
    {8'h5A, 8'h80, 16'h0155, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; hold(H); scl = 1'b1; hold(H);
    mSda = 1'b0; hold(H); scl = 1'b0; hold(H);
  endtask

  task automatic busStop();
    mSda = 1'b0; hold(H); scl = 1'b1; hold(H); mSda = 1'b1; hold(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    end
    mSda = 1'b1; hold(H); scl = 1'b1; hold(H / 2);
    ack = !sdaLine;
    hold(H / 2); scl = 1'b0;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(H); scl = 1'b1; hold(H / 2);
      b[i] = sdaLine;
      hold(H / 2); scl = 1'b0;
    end
    mSda = !ackIt; hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    mSda = 1'b1;
  endtask

  task automatic takeByte(input string tag, input logic [7:0] exp, input logic instr);
    chk(tag, cmdValid, 1'b1);
    chk(tag, cmdData, exp);
    chk(tag, cmdInstr, instr);
    hold(20);
    chk("R9 held", {cmdValid, cmdData}, {1'b1, exp});
    cmdReady = 1'b1; hold(1); cmdReady = 1'b0; hold(1);
    chk("R9 cleared", cmdValid, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         txnBase;
    hold(5);
    chk("R1 reset oe", sdaOe, 1'b0);
    chk("R1 reset valid", cmdValid, 1'b0);
    rstN = 1'b1; hold(10);

    // R1: clocked traffic without a start condition is ignored
    scl = 1'b0; hold(H);
    sendByte(8'h5A, ack);
    chk("R1 no start ack", ack, 1'b0);
    chk("R1 no start valid", cmdValid, 1'b0);
    scl = 1'b1; hold(H);

    foreach (VEC[v]) begin
      logic [7:0]  id, ins;
      logic [15:0] dat;
      logic        expAck;
      {id, ins, dat, nvBusy, expAck} = VEC[v];
      busStart();
      sendByte(id, ack);
      chk(expAck ? "R2 id ack" : (nvBusy ? "R4 busy nack" : "R3 mismatch nack"), ack, expAck);
      sendByte(ins, ack);
      chk("R5 instr ack", ack, expAck);
      if (expAck) takeByte("R5 instr byte", ins, 1'b1);
      else chk("R3 nothing delivered", cmdValid, 1'b0);
      sendByte(dat[15:8], ack);
      chk("R6 upper ack", ack, expAck);
      if (expAck) takeByte("R6 upper byte", dat[15:8], 1'b0);
      sendByte(dat[7:0], ack);
      chk("R6 lower ack", ack, expAck);
      if (expAck) takeByte("R6 lower byte", dat[7:0], 1'b0);
      else chk("R3 nothing delivered", cmdValid, 1'b0);
      busStop();
      nvBusy = 1'b0;
      hold(H);
    end
    chk("R11 addressed stops", txnCnt, 3);

    // R12: short glitch on the clock line is not a bit
    busStart();
    scl = 1'b1; hold(2); scl = 1'b0; hold(H);
    sendByte(8'h5A, ack);
    chk("R12 id ack after glitch", ack, 1'b1);
    sendByte(8'h12, ack);
    takeByte("R12 byte intact", 8'h12, 1'b1);
    busStop(); hold(H);

    // R10: restart in the middle of the identification byte
    busStart();
    for (int i = 7; i >= 4; i--) begin
      mSda = 1'(8'h5A >> i); hold(H); scl = 1'b1; hold(H); scl = 1'b0;
    end
    busStart();
    sendByte(8'h5A, ack);
    chk("R10 id ack after restart", ack, 1'b1);
    sendByte(8'h34, ack);
    takeByte("R10 instr after restart", 8'h34, 1'b1);
    busStop(); hold(H);

    // R7 / R8: read with master ACK then NACK
    txnBase = txnCnt;
    rdTakeCnt = 0;
    busStart();
    sendByte(8'h5B, ack);
    chk("R2 read id ack", ack, 1'b1);
    chk("R2 read flag", cmdRead, 1'b1);
    rdData = 8'h2A;
    sendByte(8'hA0, ack);
    chk("R5 read instr ack", ack, 1'b1);
    takeByte("R5 read instr", 8'hA0, 1'b1);
    rdData = 8'h81;
    readByte(1'b1, rb);
    chk("R7 first read byte", rb, 8'h2A);
    readByte(1'b0, rb);
    chk("R8 byte after ack", rb, 8'h81);
    chk("R7 take count", rdTakeCnt, 2);
    mSda = 1'b1; hold(H); scl = 1'b1; hold(H / 2);
    chk("R8 released after nack", {sdaOe, sdaLine}, 2'b01);
    hold(H / 2); scl = 1'b0;
    busStop(); hold(H);
    chk("R11 stop pulse", txnCnt - txnBase, 1);
    chk("R11 released", sdaOe, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule